// File: doc/BRIEF.md
# Dual Wiper Serial Command Engine

This block is the digital core of a two-channel programmable rheostat. A host talks to it over a 4-wire SPI link made of an active-low select, a serial clock, a data input and a data output. Each transfer carries one 24-bit word, sent MSB first. The top nibble is a command, the next nibble is an address, and the low 16 bits are data. When select returns high after exactly 24 clock edges, the block decodes the word. It then acts on two 10-bit wiper registers, which drive the resistor taps, and on a bank of sixteen 16-bit storage registers.

The commands cover the following operations. Each step, shift and read-back command targets either the channel picked by address bit 0 or both channels.
- Write a wiper directly, or write a storage register.
- Copy a wiper into storage, or load a wiper back from storage.
- Reload both wipers from storage at once.
- Step a wiper up or down by one.
- Double or halve a wiper, which is one 6 dB step.
- Read back a wiper or a storage register.

The data output always shifts out the previous word, so several devices can be chained. After a read command, the low 16 bits of that echo carry the selected register instead.

The serial pins are sampled by a faster system clock, and edges are detected there. The storage bank is made of plain reset registers. It takes no program time.

Top module: `dual_wiper_spi`

## Requirements
- R1: A frame is shifted in MSB first on SCLK rising edges while cs_n is low. Word bits [23:20] are the command and bits [19:16] are the address. Address bit 0 (word bit 16) selects the wiper channel. Bits [15:0] are the data.
- R2: A command runs only when cs_n rises after exactly 24 SCLK rising edges. A frame of any other length changes no register.
- R3: Command 11 loads data[9:0] into the selected wiper. Command 3 loads all of data[15:0] into storage[address].
- R4: Command 14 adds one to the selected wiper and command 15 adds one to both wipers; neither goes past 0x3FF. Command 6 subtracts one from the selected wiper and command 7 from both; neither goes below 0. All four ignore the data bits.
- R5: Command 4 halves the selected wiper and command 5 halves both. Command 12 doubles the selected wiper and command 13 doubles both, with the result limited to 0x3FF. All four ignore the data bits.
- R6: Command 2 copies the selected wiper, zero-extended, into storage at the same index. Command 1 loads the selected wiper from the low 10 bits of that storage entry. Command 8 loads wiper 0 and wiper 1 from storage 0 and storage 1.
- R7: During a frame, sdo presents the previous 24-bit word MSB first. The first bit is valid after cs_n falls, and each later bit is valid after an SCLK falling edge.
- R8: After command 9 (read storage[address]) or command 10 (read the selected wiper, zero-extended), the next frame's echo carries that value in bits [15:0]. Bits [23:16] still hold the read command's own byte.
- R9: Reset state: storage 0 and 1 hold 0x0200, other storage entries hold 0, both wipers hold 0x200, and the echo register holds zero. sdo is low whenever cs_n is high.
- R10: Command 0 changes no wiper or storage register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out; low while cs_n is high |
| wiper0 | output | 10 | Wiper position of channel 0 |
| wiper1 | output | 10 | Wiper position of channel 1 |

## Verification
Every serial pin passes through one input register, and every action takes effect on the following clock edge. So a wiper or storage update is visible two clocks after cs_n rises, and an sdo bit settles two clocks after SCLK falls or cs_n falls. The bench holds each SCLK level for four clocks. It samples sdo just before each SCLK rise and checks the wipers six clocks after cs_n rises, so every result is read well after it is due. Each frame's captured echo is compared with the word sent one frame earlier, with read data patched in where required. This makes the echo and read-back path part of every check.

// File: rtl/dual_wiper_spi.sv
module dual_wiper_spi #(
  parameter int WIPER_W = 10,
  parameter int DATA_W  = 16,
  parameter int ADDR_W  = 4,
  parameter int CMD_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               sclk,
  input  logic               sdi,
  output logic               sdo,
  output logic [WIPER_W-1:0] wiper0,
  output logic [WIPER_W-1:0] wiper1
);
  localparam int FRAME_W = CMD_W + ADDR_W + DATA_W;
  localparam int DEPTH   = 1 << ADDR_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0]   FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0]   OVER = CNT_W'(FRAME_W + 1);
  localparam logic [WIPER_W-1:0] WMAX = '1;
  localparam logic [WIPER_W-1:0] WMID = {1'b1, {(WIPER_W-1){1'b0}}};

  localparam logic [CMD_W-1:0] OP_RESTORE = CMD_W'(1);
  localparam logic [CMD_W-1:0] OP_STORE   = CMD_W'(2);
  localparam logic [CMD_W-1:0] OP_WMEM    = CMD_W'(3);
  localparam logic [CMD_W-1:0] OP_RELOAD  = CMD_W'(8);
  localparam logic [CMD_W-1:0] OP_RMEM    = CMD_W'(9);
  localparam logic [CMD_W-1:0] OP_RWIP    = CMD_W'(10);
  localparam logic [CMD_W-1:0] OP_WWIP    = CMD_W'(11);

  logic cs_q, cs_p, sck_q, sck_p, sdi_q;
  logic [FRAME_W-1:0] sr;
  logic [CNT_W-1:0]   cnt;
  logic               sdo_r;
  logic [WIPER_W-1:0] wip [2];
  logic [DATA_W-1:0]  mem [DEPTH];

  wire cs_fall  = cs_p & ~cs_q;
  wire cs_rise  = ~cs_p & cs_q;
  wire sck_rise = ~cs_q & sck_q & ~sck_p;
  wire sck_fall = ~cs_q & ~sck_q & sck_p;
  wire exec     = cs_rise & (cnt == FULL);

  wire [CMD_W-1:0]  cmd  = sr[FRAME_W-1 -: CMD_W];
  wire [ADDR_W-1:0] addr = sr[DATA_W +: ADDR_W];
  wire [DATA_W-1:0] data = sr[DATA_W-1:0];
  wire              sel  = addr[0];

  assign wiper0 = wip[0];
  assign wiper1 = wip[1];
  assign sdo    = cs_q ? 1'b0 : sdo_r;

  function automatic logic [WIPER_W-1:0] step(input logic [WIPER_W-1:0] w,
                                              input logic [CMD_W-1:0] c);
    case (c[3:1])
      3'b010:  step = w >> 1;
      3'b011:  step = (w == '0) ? w : w - 1'b1;
      3'b110:  step = w[WIPER_W-1] ? WMAX : (w << 1);
      3'b111:  step = (w == WMAX) ? w : w + 1'b1;
      default: step = w;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q <= 1'b1; cs_p <= 1'b1;
      sck_q <= 1'b0; sck_p <= 1'b0; sdi_q <= 1'b0;
    end else begin
      cs_q <= cs_n; cs_p <= cs_q;
      sck_q <= sclk; sck_p <= sck_q; sdi_q <= sdi;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr <= '0; cnt <= '0; sdo_r <= 1'b0;
    end else if (cs_fall) begin
      cnt   <= '0;
      sdo_r <= sr[FRAME_W-1];
    end else if (sck_rise) begin
      sr  <= {sr[FRAME_W-2:0], sdi_q};
      cnt <= (cnt == OVER) ? cnt : cnt + 1'b1;
    end else if (sck_fall) begin
      sdo_r <= sr[FRAME_W-1];
    end else if (exec && cmd == OP_RMEM) begin
      sr[DATA_W-1:0] <= mem[addr];
    end else if (exec && cmd == OP_RWIP) begin
      sr[DATA_W-1:0] <= DATA_W'(wip[sel]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= (k < 2) ? DATA_W'(WMID) : '0;
    end else if (exec) begin
      if (cmd == OP_STORE) mem[ADDR_W'(sel)] <= DATA_W'(wip[sel]);
      else if (cmd == OP_WMEM) mem[addr] <= data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 2; k++) wip[k] <= WMID;
    end else if (exec) begin
      for (int k = 0; k < 2; k++) begin
        if (cmd == OP_RELOAD || (cmd == OP_RESTORE && sel == 1'(k)))
          wip[k] <= mem[k][WIPER_W-1:0];
        else if (cmd == OP_WWIP && sel == 1'(k))
          wip[k] <= data[WIPER_W-1:0];
        else if (cmd[2] && (cmd[0] || sel == 1'(k)))
          wip[k] <= step(wip[k], cmd);
      end
    end
  end

  assert_short_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && cnt != FULL) |=> ($stable(wiper0) && $stable(wiper1)));
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !exec |=> ($stable(wiper0) && $stable(wiper1)));
  assert_wiper_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && cmd == OP_WWIP && !sel) |=> wiper0 == $past(data[WIPER_W-1:0]));
  assert_inc_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && cmd[3:1] == 3'b111) |=> (wiper0 >= $past(wiper0) && wiper1 >= $past(wiper1)));
  assert_dec_no_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && cmd[3:1] == 3'b011) |=> (wiper0 <= $past(wiper0) && wiper1 <= $past(wiper1)));
  assert_read_patch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && cmd == OP_RWIP) |=> sr[DATA_W-1:0] == DATA_W'($past(wip[sel])));
endmodule

// File: tb/dual_wiper_spi_bench.sv
`timescale 1ns/1ps
module dual_wiper_spi_bench;
  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, sdi = 0;
  logic sdo;
  logic [9:0] wiper0, wiper1;
  int errors = 0, checks = 0;

  logic [9:0]  exp_w [2];
  logic [15:0] exp_m [16];
  logic [23:0] exp_echo;
  bit          skip_echo;
  string       echo_tag;

  always #4 clk = ~clk;

  dual_wiper_spi u_dual_wiper_spi (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .wiper0(wiper0), .wiper1(wiper1));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [23:0] w, input int nbits, output logic [23:0] got);
    got = '0;
    @(negedge clk) cs_n = 0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      if (i < 24) sdi = w[23-i]; else sdi = 1'b1;
      repeat (4) @(negedge clk);
      if (i < 24) got[23-i] = sdo;
      sclk = 1;
      repeat (4) @(negedge clk);
      sclk = 0;
    end
    repeat (4) @(negedge clk);
    cs_n = 1;
    repeat (6) @(negedge clk);
  endtask

  function automatic logic [9:0] model_step(logic [9:0] v, logic [3:0] c);
    int x = int'(v);
    case (c)
      4, 5:    x = x / 2;
      6, 7:    x = (x > 0) ? x - 1 : 0;
      12, 13:  x = (2 * x > 1023) ? 1023 : 2 * x;
      14, 15:  x = (x < 1023) ? x + 1 : 1023;
      default: ;
    endcase
    return 10'(x);
  endfunction

  task automatic check_state(string req);
    check({req, " wiper0"}, 32'(wiper0), 32'(exp_w[0]));
    check({req, " wiper1"}, 32'(wiper1), 32'(exp_w[1]));
    check("R9 sdo low while idle", 32'(sdo), 0);
  endtask

  task automatic run(input logic [3:0] c, input logic [3:0] a, input logic [15:0] d, input string req);
    logic [23:0] got;
    logic [23:0] w = {c, a, d};
    logic [23:0] nxt = w;
    xfer(w, 24, got);
    if (!skip_echo) check(echo_tag, 32'(got), 32'(exp_echo));
    if (c == 9)  nxt[15:0] = exp_m[a];
    if (c == 10) nxt[15:0] = {6'b0, exp_w[a[0]]};
    case (c)
      1: exp_w[a[0]] = exp_m[a[0]][9:0];
      2: exp_m[a[0]] = {6'b0, exp_w[a[0]]};
      3: exp_m[a] = d;
      8: begin exp_w[0] = exp_m[0][9:0]; exp_w[1] = exp_m[1][9:0]; end
      11: exp_w[a[0]] = d[9:0];
      4, 6, 12, 14: exp_w[a[0]] = model_step(exp_w[a[0]], c);
      5, 7, 13, 15: begin
        exp_w[0] = model_step(exp_w[0], c);
        exp_w[1] = model_step(exp_w[1], c);
      end
      default: ;
    endcase
    check_state(req);
    exp_echo  = nxt;
    skip_echo = 0;
    echo_tag  = (c == 9 || c == 10) ? "R8 read data in echo" : "R7 echo of previous frame";
  endtask

  task automatic short_frame(input int nbits);
    logic [23:0] got;
    xfer({4'd11, 4'd0, 16'h03FF}, nbits, got);
    check_state("R2 short/long frame discarded");
    skip_echo = 1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [9:0] starts [6];
    logic [3:0] ops [8];
    starts = '{10'h000, 10'h001, 10'h200, 10'h3FE, 10'h3FF, 10'h155};
    ops = '{4'd4, 4'd5, 4'd6, 4'd7, 4'd12, 4'd13, 4'd14, 4'd15};
    for (int k = 0; k < 16; k++) exp_m[k] = (k < 2) ? 16'h0200 : 16'h0000;
    exp_w[0] = 10'h200; exp_w[1] = 10'h200;
    exp_echo = '0; skip_echo = 0; echo_tag = "R9 reset echo zero";
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    check_state("R9 reset wipers");

    run(4'd0, 4'd1, 16'hFFFF, "R10 nop");
    // R9 reset storage contents read back through R8 echo
    for (int a = 0; a < 16; a++) run(4'd9, 4'(a), 16'h0000, "R9 storage read");
    // R3 storage writes over all addresses, then R1 address decode readback
    for (int a = 0; a < 16; a++) run(4'd3, 4'(a), 16'(a * 16'h1111) ^ 16'h5A5A, "R3 storage write");
    for (int a = 0; a < 16; a++) run(4'd9, 4'(a), 16'h0000, "R1 storage read");
    run(4'd8, 4'd0, 16'hFFFF, "R6 reload all");
    // R3 wiper writes with upper data bits set
    foreach (starts[i]) begin
      run(4'd11, 4'd0, {6'h3F, starts[i]}, "R3 wiper0 write");
      run(4'd11, 4'd1, {6'h2A, ~starts[i]}, "R3 wiper1 write");
      run(4'd10, 4'd0, 16'h0000, "R3 wiper read");
      run(4'd10, 4'd1, 16'h0000, "R3 wiper read");
    end
    // R4 R5 step and shift, both targets, data ignored
    foreach (ops[j]) foreach (starts[i]) for (int a = 0; a < 2; a++) begin
      run(4'd11, 4'd0, {6'h00, starts[i]}, "R3 setup");
      run(4'd11, 4'd1, {6'h00, ~starts[i]}, "R3 setup");
      run(ops[j], 4'(a), 16'hABCD, (ops[j][3:1] == 3'b010 || ops[j][3:1] == 3'b110) ? "R5 shift" : "R4 step");
    end
    // R6 store and restore
    run(4'd11, 4'd0, 16'h0123, "R6 setup");
    run(4'd11, 4'd1, 16'h0345, "R6 setup");
    run(4'd2, 4'd0, 16'h0000, "R6 store wiper0");
    run(4'd2, 4'd1, 16'hFFFF, "R6 store wiper1");
    run(4'd11, 4'd0, 16'h0000, "R6 setup");
    run(4'd11, 4'd1, 16'h0000, "R6 setup");
    run(4'd1, 4'd0, 16'h0000, "R6 restore wiper0");
    run(4'd9, 4'd1, 16'h0000, "R6 storage1 read");
    run(4'd3, 4'd1, 16'hFC0F, "R6 setup");
    run(4'd1, 4'd1, 16'h0000, "R6 restore low bits");
    run(4'd0, 4'd0, 16'h0000, "R10 nop");
    // R2 wrong-length frames
    short_frame(23);
    run(4'd0, 4'd0, 16'h0000, "R10 nop");
    short_frame(25);
    run(4'd0, 4'd0, 16'h0000, "R10 nop");
    run(4'd0, 4'd0, 16'h0000, "R7 echo");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule